// File: doc/BRIEF.md
# Dual-Bank Endpoint Buffer Controller

This block holds the packet storage of one device endpoint as two ping-pong banks. For an IN endpoint, the local side fills a bank byte by byte. The bank is then committed, and the bus side transmits it and hands it back. For an OUT endpoint, the bus side fills a bank with a received packet. The local side then reads it out and releases it. While one bank is held by one side, the other side can work on the second bank.

A bank can be committed or released by a software pulse. An optional auto-commit mode does the same work without software: it acts when an IN bank fills, when the last byte of an OUT bank is read, or when a DMA end-of-buffer pulse arrives. Auto-commit is ignored when the endpoint is configured as a control endpoint. The block also produces a DMA request, and it can force that request low while an enabled endpoint interrupt is pending.

The byte ports use a valid/ready handshake, and a byte moves on a clock edge where both are high. `wr_ready` is high whenever the endpoint is enabled and configured as IN. A byte accepted while the current bank is committed or full is dropped and flagged. `bus_rx_ready` is low while the bus-side bank still holds an unreleased packet, which pauses the bus. `rd_valid` is high only while unread bytes remain in a committed OUT bank.

Top module: `ep_pingpong_buf`

## Requirements
- R1: After `rst_n` low, or after one cycle with `bus_reset` high, both banks are empty and uncommitted, `bank_rdy`=0, `busy_banks`=0, `cur_bank`=0 and `drop_err`=0. `ep_enabled` is then 1 when the parameter `EP_INDEX` is 0.
- R2: With `cfg_dir_in`=1, `cfg_auto_commit`=1 and `cfg_control`=0, consider the write that stores byte number `BANK_BYTES` into the current bank. In the next cycle, that bank's bit in `bank_rdy` (bit n for bank n) is 1 and `cur_bank` has toggled.
- R3: In IN mode with auto-commit and `cfg_dma_eob_en` both on, a `dma_eob` pulse commits a partly filled current bank. `bus_tx_len` then reports the number of bytes written.
- R4: A `tx_commit` pulse in IN mode commits the current uncommitted bank whatever its fill level, with or without auto-commit. An empty bank gives `bus_tx_len`=0, which is a zero-length packet.
- R5: With `cfg_control`=1, auto-commit has no effect, so a full IN bank stays uncommitted.
- R6: An IN byte written while the current bank is committed is discarded, and the bank length is unchanged. `drop_err` becomes 1 and holds until a reset or a bus reset.
- R7: While a committed IN bank is owned by the bus side, `bus_tx_valid`=1 and `bus_tx_data` returns the stored byte at `bus_tx_addr`. A `bus_tx_done` pulse frees that bank. Banks are handed out in commit order.
- R8: In OUT mode, a `bus_rx` transfer with `bus_rx_last`=1 commits the bus-side bank. `bus_rx_ready` is 0 while the bus-side bank is committed. The local read stream returns the bytes in arrival order, with `rd_last`=1 on the final byte of each packet.
- R9: In OUT mode with auto-commit, reading the final byte releases the bank in the next cycle and toggles `cur_bank`.
- R10: In OUT mode, the current committed bank is released and its unread remainder is discarded in two cases: a `dma_eob` pulse (with auto-commit and `cfg_dma_eob_en` on), or a `rx_discard` pulse (always).
- R11: `dma_req` is 0 while `cfg_irq_blocks_dma`, `irq_src` and `irq_en` are all 1. Otherwise it is 1 in these cases: the endpoint is IN and its current bank is uncommitted, or the endpoint is OUT and `rd_valid` is 1.
- R12: `busy_banks` equals the number of 1 bits in `bank_rdy`, and `cur_bank` names the local side's bank.
- R13: A `sw_en_wr` pulse loads `sw_en_val` into `ep_enabled`. While the endpoint is disabled, `wr_ready`, `bus_rx_ready` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous bus reset; flushes banks, restores enable default |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_control | input | 1 | Endpoint is a control endpoint (disables auto-commit) |
| cfg_auto_commit | input | 1 | Auto-commit enable |
| cfg_dma_eob_en | input | 1 | Let `dma_eob` commit or release under auto-commit |
| cfg_irq_blocks_dma | input | 1 | Pending endpoint interrupt forces `dma_req` low |
| sw_en_wr | input | 1 | Load enable bit |
| sw_en_val | input | 1 | Value loaded into the enable bit |
| tx_commit | input | 1 | Manual commit of current IN bank |
| rx_discard | input | 1 | Manual release of current OUT bank |
| wr_valid | input | 1 | Local IN byte valid |
| wr_ready | output | 1 | Local IN byte accepted |
| wr_data | input | DW | Local IN byte |
| rd_valid | output | 1 | Local OUT byte valid |
| rd_ready | input | 1 | Local side takes OUT byte |
| rd_data | output | DW | Local OUT byte |
| rd_last | output | 1 | Final byte of the OUT packet |
| bus_rx_valid | input | 1 | Bus OUT byte valid |
| bus_rx_ready | output | 1 | Bus OUT byte accepted |
| bus_rx_data | input | DW | Bus OUT byte |
| bus_rx_last | input | 1 | Final byte of the bus OUT packet |
| bus_tx_valid | output | 1 | A committed IN packet is waiting |
| bus_tx_len | output | CW | Length of the waiting IN packet |
| bus_tx_addr | input | AW | Byte index into the waiting IN packet |
| bus_tx_data | output | DW | Byte at `bus_tx_addr` |
| bus_tx_done | input | 1 | Bus finished the IN packet; free its bank |
| dma_eob | input | 1 | DMA end-of-buffer pulse |
| irq_src | input | 1 | Endpoint interrupt source level |
| irq_en | input | 1 | Endpoint interrupt enable |
| dma_req | output | 1 | DMA request |
| ep_enabled | output | 1 | Endpoint enable state |
| cur_bank | output | 1 | Local side's current bank |
| bank_rdy | output | 2 | Committed flag per bank |
| busy_banks | output | 2 | Number of committed banks |
| drop_err | output | 1 | Sticky dropped-byte flag |

## Verification
Every flag, length, pointer and error bit is a register that updates on the edge where the causing handshake or pulse is sampled. These results are therefore due one cycle after the stimulus. The bench drives stimulus on the falling edge and checks these results on the next falling edge. `rd_data`, `rd_last`, `bus_tx_data`, `bus_tx_valid`, `wr_ready`, `bus_rx_ready` and `dma_req` are combinational from that state and the inputs. The monitor samples them one nanosecond after the falling edge, before the rising edge that consumes them. It pops an expected byte only for handshakes that will really take place.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
  localparam int NBANK = 2;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/ep_bank_ram.sv
module ep_bank_ram #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_buf_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  localparam int AW = $clog2(BANK_BYTES),
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              en,
  input  logic              dir_in,
  input  logic              auto_on,
  input  logic              eob_en,
  input  logic              tx_commit,
  input  logic              rx_discard,
  input  logic              dma_eob,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              bus_rx_valid,
  output logic              bus_rx_ready,
  input  logic              bus_rx_last,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_last,
  input  logic              bus_tx_done,
  output logic              bus_tx_valid,
  output logic [CW-1:0]     bus_tx_len,
  input  logic [AW-1:0]     bus_tx_addr,
  output logic              mem_we,
  output logic [AW:0]       mem_waddr,
  output logic [AW:0]       mem_rd_addr,
  output logic [AW:0]       mem_tx_addr,
  output logic              cur_bank,
  output logic [NBANK-1:0]  bank_rdy,
  output logic              drop_err
);
  localparam logic [CW-1:0] FULL   = CW'(BANK_BYTES);
  localparam logic [CW-1:0] ONE    = CW'(1);

  bank_e            loc_q, bus_q;
  logic [NBANK-1:0] rdy_q;
  logic [CW-1:0]    cnt_q [NBANK];
  logic [CW-1:0]    rptr_q;
  logic             drop_q;

  // IN direction events
  logic in_wr, in_drop, in_store, in_fill, in_eob, in_man, in_val, in_done;
  // OUT direction events
  logic out_wr, out_store, out_drop, out_done, rd_fire, out_rel;

  assign wr_ready     = en && dir_in;
  assign in_wr        = wr_valid && wr_ready;
  assign in_drop      = in_wr && (rdy_q[loc_q] || cnt_q[loc_q] == FULL);
  assign in_store     = in_wr && !in_drop;
  assign in_fill      = in_store && auto_on && (cnt_q[loc_q] + ONE == FULL);
  assign in_eob       = dma_eob && eob_en && auto_on && en && dir_in && !rdy_q[loc_q];
  assign in_man       = tx_commit && en && dir_in && !rdy_q[loc_q];
  assign in_val       = in_fill || in_eob || in_man;
  assign bus_tx_valid = en && dir_in && rdy_q[bus_q];
  assign bus_tx_len   = cnt_q[bus_q];
  assign in_done      = bus_tx_done && bus_tx_valid;

  assign bus_rx_ready = en && !dir_in && !rdy_q[bus_q];
  assign out_wr       = bus_rx_valid && bus_rx_ready;
  assign out_store    = out_wr && (cnt_q[bus_q] != FULL);
  assign out_drop     = out_wr && (cnt_q[bus_q] == FULL);
  assign out_done     = out_wr && bus_rx_last;
  assign rd_valid     = en && !dir_in && rdy_q[loc_q] && (rptr_q < cnt_q[loc_q]);
  assign rd_last      = (rptr_q + ONE) == cnt_q[loc_q];
  assign rd_fire      = rd_valid && rd_ready;
  assign out_rel      = !dir_in && rdy_q[loc_q] &&
                        ((rd_fire && rd_last && auto_on) ||
                         (dma_eob && eob_en && auto_on && en) ||
                         rx_discard);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam bank_e ME = bank_e'(b);
    logic          set_b, clr_b, inc_b;
    logic          rdy_r;
    logic [CW-1:0] cnt_r;

    assign set_b = (in_val && loc_q == ME) || (out_done && bus_q == ME);
    assign clr_b = (in_done && bus_q == ME) || (out_rel && loc_q == ME);
    assign inc_b = (in_store && loc_q == ME) || (out_store && bus_q == ME);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_r <= 1'b0;
        cnt_r <= '0;
      end else if (bus_reset || clr_b) begin
        rdy_r <= 1'b0;
        cnt_r <= '0;
      end else begin
        if (set_b) rdy_r <= 1'b1;
        if (inc_b) cnt_r <= cnt_r + ONE;
      end
    end

    assign rdy_q[b] = rdy_r;
    assign cnt_q[b] = cnt_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q  <= BANK_A;
      bus_q  <= BANK_A;
      rptr_q <= '0;
      drop_q <= 1'b0;
    end else if (bus_reset) begin
      loc_q  <= BANK_A;
      bus_q  <= BANK_A;
      rptr_q <= '0;
      drop_q <= 1'b0;
    end else begin
      if (in_val || out_rel)   loc_q <= other_bank(loc_q);
      if (in_done || out_done) bus_q <= other_bank(bus_q);
      if (out_rel)             rptr_q <= '0;
      else if (rd_fire)        rptr_q <= rptr_q + ONE;
      if (in_drop || out_drop) drop_q <= 1'b1;
    end
  end

  assign mem_we      = in_store || out_store;
  assign mem_waddr   = dir_in ? {loc_q, cnt_q[loc_q][AW-1:0]}
                              : {bus_q, cnt_q[bus_q][AW-1:0]};
  assign mem_rd_addr = {loc_q, rptr_q[AW-1:0]};
  assign mem_tx_addr = {bus_q, bus_tx_addr};
  assign cur_bank    = loc_q;
  assign bank_rdy    = rdy_q;
  assign drop_err    = drop_q;

  // R2: filling the last slot under auto-commit commits that bank
  p_auto_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && !bus_reset) |=> rdy_q[$past(loc_q)]);

  // R4: manual commit marks the current bank committed
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_man && !bus_reset) |=> rdy_q[$past(loc_q)]);

  // R6: error flag is sticky
  p_drop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && !bus_reset) |=> drop_q);

  // R9: last read under auto-commit frees the bank
  p_auto_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_last && auto_on && !bus_reset) |=> !rdy_q[$past(loc_q)]);
endmodule

// File: rtl/ep_dma_gate.sv
module ep_dma_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic irq_blocks,
  input  logic irq_src,
  input  logic irq_en,
  output logic dma_req
);
  logic irq_live;

  assign irq_live = irq_src && irq_en;
  assign dma_req  = want && !(irq_blocks && irq_live);

  // R11: pending enabled interrupt suppresses DMA when gating is on
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_blocks && irq_src && irq_en) |-> !dma_req);
endmodule

// File: rtl/ep_pingpong_buf.sv
module ep_pingpong_buf
  import ep_buf_pkg::*;
#(
  parameter int DW         = 8,
  parameter int BANK_BYTES = 64,
  parameter int EP_INDEX   = 0,
  localparam int AW = $clog2(BANK_BYTES),
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          cfg_dir_in,
  input  logic          cfg_control,
  input  logic          cfg_auto_commit,
  input  logic          cfg_dma_eob_en,
  input  logic          cfg_irq_blocks_dma,
  input  logic          sw_en_wr,
  input  logic          sw_en_val,
  input  logic          tx_commit,
  input  logic          rx_discard,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  input  logic          bus_rx_valid,
  output logic          bus_rx_ready,
  input  logic [DW-1:0] bus_rx_data,
  input  logic          bus_rx_last,
  output logic          bus_tx_valid,
  output logic [CW-1:0] bus_tx_len,
  input  logic [AW-1:0] bus_tx_addr,
  output logic [DW-1:0] bus_tx_data,
  input  logic          bus_tx_done,
  input  logic          dma_eob,
  input  logic          irq_src,
  input  logic          irq_en,
  output logic          dma_req,
  output logic          ep_enabled,
  output logic          cur_bank,
  output logic [1:0]    bank_rdy,
  output logic [1:0]    busy_banks,
  output logic          drop_err
);
  localparam logic EN_DEFAULT = (EP_INDEX == 0);

  logic          en_q;
  logic          auto_on;
  logic          mem_we;
  logic [AW:0]   mem_waddr, mem_rd_addr, mem_tx_addr;
  logic [DW-1:0] mem_wdata;
  logic          dma_want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= EN_DEFAULT;
    else if (bus_reset) en_q <= EN_DEFAULT;
    else if (sw_en_wr)  en_q <= sw_en_val;
  end

  assign auto_on   = cfg_auto_commit && !cfg_control;
  assign mem_wdata = cfg_dir_in ? wr_data : bus_rx_data;

  ep_bank_ctrl #(.BANK_BYTES(BANK_BYTES)) u_ctrl (
    .clk, .rst_n, .bus_reset,
    .en           (en_q),
    .dir_in       (cfg_dir_in),
    .auto_on      (auto_on),
    .eob_en       (cfg_dma_eob_en),
    .tx_commit, .rx_discard, .dma_eob,
    .wr_valid, .wr_ready,
    .bus_rx_valid, .bus_rx_ready, .bus_rx_last,
    .rd_valid, .rd_ready, .rd_last,
    .bus_tx_done, .bus_tx_valid, .bus_tx_len, .bus_tx_addr,
    .mem_we, .mem_waddr, .mem_rd_addr, .mem_tx_addr,
    .cur_bank, .bank_rdy, .drop_err
  );

  ep_bank_ram #(.DW(DW), .AW(AW + 1)) u_ram (
    .clk,
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (mem_rd_addr),
    .rdata_a (rd_data),
    .raddr_b (mem_tx_addr),
    .rdata_b (bus_tx_data)
  );

  assign dma_want = cfg_dir_in ? (en_q && !bank_rdy[cur_bank]) : rd_valid;

  ep_dma_gate u_gate (
    .clk, .rst_n,
    .want       (dma_want),
    .irq_blocks (cfg_irq_blocks_dma),
    .irq_src, .irq_en, .dma_req
  );

  assign busy_banks = {1'b0, bank_rdy[0]} + {1'b0, bank_rdy[1]};
  assign ep_enabled = en_q;

  // R1: a bus reset restores the enable default
  p_ep0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_reset) |-> (ep_enabled == EN_DEFAULT));

  // R13: disabled endpoint moves no data
  p_dis_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_enabled |-> (!wr_ready && !bus_rx_ready && !rd_valid));
endmodule

// File: tb/test_ep_pingpong_buf.sv
`timescale 1ns/100ps
module test_ep_pingpong_buf;
  localparam int DW = 8;
  localparam int BB = 8;
  localparam int AW = $clog2(BB);
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 0, cfg_dir_in = 1, cfg_control = 0, cfg_auto_commit = 0;
  logic cfg_dma_eob_en = 0, cfg_irq_blocks_dma = 0, sw_en_wr = 0, sw_en_val = 0;
  logic tx_commit = 0, rx_discard = 0, wr_valid = 0, rd_ready = 0;
  logic bus_rx_valid = 0, bus_rx_last = 0, bus_tx_done = 0, dma_eob = 0;
  logic irq_src = 0, irq_en = 0;
  logic [DW-1:0] wr_data = '0, bus_rx_data = '0;
  logic [AW-1:0] bus_tx_addr = '0;
  logic wr_ready, rd_valid, rd_last, bus_rx_ready, bus_tx_valid, dma_req;
  logic ep_enabled, cur_bank, drop_err;
  logic [DW-1:0] rd_data, bus_tx_data;
  logic [CW-1:0] bus_tx_len;
  logic [1:0] bank_rdy, busy_banks;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [DW:0] exp_q[$];

  always #5 clk = ~clk;

  ep_pingpong_buf #(.DW(DW), .BANK_BYTES(BB), .EP_INDEX(0)) i_ep_pingpong_buf (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic in_write(input logic [7:0] d, input bit keep);
    wr_valid = 1; wr_data = d;
    tick();
    wr_valid = 0;
    if (keep) exp_q.push_back({1'b0, d});
  endtask

  task automatic bus_send(input int n, input logic [7:0] base, input int keep);
    for (int i = 0; i < n; i++) begin
      bus_rx_valid = 1; bus_rx_data = base + 8'(i); bus_rx_last = (i == n - 1);
      if (i < keep) exp_q.push_back({(i == n - 1) && (keep == n), base + 8'(i)});
      tick();
    end
    bus_rx_valid = 0; bus_rx_last = 0;
  endtask

  // Drain one committed IN packet, comparing bytes against the scoreboard (R7)
  task automatic in_drain(input int len);
    chk("R7 tx_valid", bus_tx_valid, 1);
    chk("R7 tx_len", bus_tx_len, len);
    for (int i = 0; i < len; i++) begin
      logic [DW:0] e;
      bus_tx_addr = AW'(i);
      #0.5;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
      chk("R7 tx_data", bus_tx_data, e[DW-1:0]);
    end
    bus_tx_done = 1;
    tick();
    bus_tx_done = 0;
  endtask

  // Monitor: pops expected OUT bytes on real handshakes (R8)
  always @(negedge clk) begin
    #1;
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk("R8 unexpected byte", rd_data, 32'hFFFF);
      else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        chk("R8 rd_data", rd_data, e[DW-1:0]);
        chk("R8 rd_last", rd_last, e[DW]);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 bank_rdy", bank_rdy, 0);
    chk("R1 busy", busy_banks, 0);
    chk("R1 cur_bank", cur_bank, 0);
    chk("R1 enabled", ep_enabled, 1);
    chk("R1 drop_err", drop_err, 0);

    // R2 auto-commit on full bank
    cfg_auto_commit = 1;
    for (int i = 0; i < BB; i++) in_write(8'h10 + 8'(i), 1);
    chk("R2 bank_rdy", bank_rdy, 2'b01);
    chk("R2 cur_bank", cur_bank, 1);
    chk("R12 busy", busy_banks, 1);
    in_drain(BB);
    chk("R7 freed", bank_rdy, 0);

    // R3 DMA end-of-buffer on partial bank
    cfg_dma_eob_en = 1;
    for (int i = 0; i < 3; i++) in_write(8'h40 + 8'(i), 1);
    chk("R3 not yet", bank_rdy, 0);
    dma_eob = 1; tick(); dma_eob = 0;
    chk("R3 bank_rdy", bank_rdy, 2'b10);
    chk("R3 cur_bank", cur_bank, 0);
    in_drain(3);

    // R4 manual zero-length packet
    cfg_auto_commit = 0; cfg_dma_eob_en = 0;
    tx_commit = 1; tick(); tx_commit = 0;
    chk("R4 bank_rdy", bank_rdy, 2'b01);
    in_drain(0);

    // R5 control endpoint ignores auto-commit
    cfg_auto_commit = 1; cfg_control = 1;
    for (int i = 0; i < BB; i++) in_write(8'h60 + 8'(i), 1);
    chk("R5 full not committed", bank_rdy, 0);
    chk("R11 dma while space", dma_req, 1);
    tx_commit = 1; tick(); tx_commit = 0;
    in_write(8'hA0, 1); in_write(8'hA1, 1);
    tx_commit = 1; tick(); tx_commit = 0;
    chk("R12 busy two", busy_banks, 2);
    chk("R12 cur_bank", cur_bank, 1);
    chk("R11 no dma when full", dma_req, 0);

    // R6 write to committed bank is dropped
    in_write(8'hEE, 0);
    chk("R6 drop_err", drop_err, 1);
    in_drain(BB);
    in_drain(2);
    chk("R6 sticky", drop_err, 1);

    // R1 bus reset flush
    bus_reset = 1; tick(); bus_reset = 0;
    chk("R1 flush drop", drop_err, 0);
    chk("R1 flush cur", cur_bank, 0);

    // R8 / R9 OUT with auto-release
    cfg_dir_in = 0; cfg_control = 0; cfg_auto_commit = 1;
    bus_send(4, 8'h80, 4);
    bus_send(3, 8'h90, 3);
    chk("R8 bank_rdy", bank_rdy, 2'b11);
    chk("R8 backpressure", bus_rx_ready, 0);
    rd_ready = 1;
    repeat (4) tick();
    chk("R9 first released", bank_rdy, 2'b10);
    chk("R9 cur_bank", cur_bank, 1);
    repeat (3) tick();
    rd_ready = 0;
    chk("R9 second released", bank_rdy, 0);
    chk("R8 queue empty", exp_q.size(), 0);

    // R10 truncation at DMA end-of-buffer
    cfg_dma_eob_en = 1;
    bus_send(5, 8'hC0, 2);
    rd_ready = 1; tick(); tick(); rd_ready = 0;
    chk("R10 still held", bank_rdy, 2'b01);
    dma_eob = 1; tick(); dma_eob = 0;
    chk("R10 eob release", bank_rdy, 0);
    chk("R10 cur_bank", cur_bank, 1);

    // R10 manual discard without auto
    cfg_auto_commit = 0; cfg_dma_eob_en = 0;
    bus_send(2, 8'hD0, 0);
    chk("R10 held", bank_rdy, 2'b10);
    rx_discard = 1; tick(); rx_discard = 0;
    chk("R10 discard", bank_rdy, 0);
    chk("R10 rd_valid", rd_valid, 0);

    // R11 interrupt gating of DMA
    cfg_dir_in = 1; #0.5;
    chk("R11 base", dma_req, 1);
    cfg_irq_blocks_dma = 1; irq_src = 1; irq_en = 1; #0.5;
    chk("R11 gated", dma_req, 0);
    irq_en = 0; #0.5;
    chk("R11 irq disabled", dma_req, 1);
    irq_en = 1; cfg_irq_blocks_dma = 0; #0.5;
    chk("R11 gating off", dma_req, 1);
    irq_src = 0;
    tick();

    // R13 enable control
    sw_en_wr = 1; sw_en_val = 0; tick(); sw_en_wr = 0;
    chk("R13 disabled", ep_enabled, 0);
    chk("R13 wr_ready", wr_ready, 0);
    bus_reset = 1; tick(); bus_reset = 0;
    chk("R1 ep0 re-enabled", ep_enabled, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule